// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block sits beside a host bridge and decides how each access that falls below the 1 MB line is served. A narrow byte-wide configuration write port loads a small bank of attribute bytes and one SMRAM control byte. The attribute bytes hold 2-bit access codes packed two to a byte. One code covers the 64 KB top window at 0xF0000–0xFFFFF. Twelve codes cover the 16 KB segments between 0xC0000 and 0xEFFFF. The 128 KB window at 0xA0000–0xBFFFF has no attribute code. It follows the SMRAM byte together with an SMM-active input.

For each request it gets (an address plus a read/write flag), the block returns one registered routing decision on the next cycle. The decision is one of three targets: main DRAM, DRAM mapped read-only, or forwarding to the expansion bus. A write-inhibit flag goes with the decision. The flag is raised when a write hits a read-only region. Addresses outside 0xA0000–0xFFFFF, including everything at or above 1 MB, go to DRAM and no attribute applies to them.

The low window is held by a three-state machine:
- `LW_BUS`: the window is forwarded to the bus.
- `LW_OPEN`: the window is opened to DRAM by the SMRAM open bit.
- `LW_SMM`: the window is opened to DRAM because SMM is active and the SMRAM enable bit is set.

The state is re-evaluated on every clock from the value the SMRAM byte will hold after the edge and from the SMM input. Its transitions are:
- `to_open`: from any state, when the open bit is 1.
- `to_smm`: from any state, when the open bit is 0, SMM is active and the enable bit is 1.
- `to_bus`: from any state, when neither condition holds.

When the condition is unchanged, the state stays where it is.

Top module: `legacy_mem_attr_decoder`

## Requirements
- R1: After reset every attribute byte is 0 and the SMRAM byte is 0x02. Every segment and the top window are therefore forwarded to the bus (target 2). The low window also goes to the bus, even while SMM is active.
- R2: Attribute code 3 routes a region to DRAM (target 0) for both reads and writes, with write-inhibit 0.
- R3: Attribute code 1 routes a region as read-only DRAM (target 1). Reads have write-inhibit 0 and writes have write-inhibit 1.
- R4: Attribute codes 0 and 2 forward the region to the bus (target 2) with write-inhibit 0.
- R5: The 16 KB segment i at 0xC0000 + i·0x4000 (i = 0..11) takes its code from the byte at offset 0x5A + (i>>1). Even segments use bits 1:0 and odd segments use bits 5:4. Bits 3:2 and 7:6 have no effect.
- R6: The window 0xF0000–0xFFFFF takes its code from bits 5:4 of the byte at offset 0x59. The other bits of that byte have no effect on it.
- R7: When bit 6 of the SMRAM byte (offset 0x72) is 1, the window 0xA0000–0xBFFFF goes to DRAM (target 0) whatever the SMM input.
- R8: When bit 6 is 0, the low window goes to DRAM only while SMM is active and bit 3 is 1. It returns to the bus as soon as SMM drops.
- R9: Addresses below 0xA0000 or at or above 0x100000 go to DRAM (target 0) with write-inhibit 0, whatever the attribute codes.
- R10: A configuration write to any offset other than 0x59–0x5F and 0x72 changes no routing decision.
- R11: A request sampled at a clock edge gives rsp_valid and its decision right after that edge, for exactly one cycle. A configuration write or SMM change applies to requests sampled from the next edge onwards. rsp_valid is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration byte value |
| smm_active | input | 1 | System management mode is active |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | Request is a write (0 = read) |
| req_addr | input | ADDR_W | Request address |
| rsp_valid | output | 1 | Decision valid |
| rsp_target | output | 2 | 0 = DRAM, 1 = read-only DRAM, 2 = expansion bus |
| rsp_wr_inhibit | output | 1 | Write blocked by a read-only region |

## Verification
The bench builds the block with its default parameters: a 32-bit address, seven attribute bytes based at 0x59, twelve 16 KB segments and the SMRAM byte at 0x72. The 32-bit address width lets the bench probe addresses above 1 MB whose low 20 bits alias a read-only segment, which shows that the range test looks at the upper bits. With twelve segments the first and last segment and both nibbles of the last attribute byte are in reach. The bench also walks the 16 KB boundary at 0xC3FFF/0xC4000 and drives the SMM input through every low-window state.

// File: rtl/legacy_attr_pkg.sv
package legacy_attr_pkg;

    typedef enum logic [1:0] {
        TGT_DRAM    = 2'd0,
        TGT_DRAM_RO = 2'd1,
        TGT_BUS     = 2'd2
    } route_t;

    typedef enum logic [1:0] {
        LW_BUS  = 2'd0,
        LW_OPEN = 2'd1,
        LW_SMM  = 2'd2
    } lowwin_t;

    localparam logic [1:0] CODE_RO = 2'd1;
    localparam logic [1:0] CODE_RW = 2'd3;

endpackage

// File: rtl/lma_cfg_regs.sv
module lma_cfg_regs #(
    parameter int          CFG_AW     = 8,
    parameter int          ATTR_BYTES = 7,
    parameter logic [7:0]  ATTR_BASE  = 8'h59,
    parameter logic [7:0]  SMRAM_OFS  = 8'h72,
    parameter logic [7:0]  SMRAM_RST  = 8'h02
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [7:0]              cfg_wdata,
    output logic [ATTR_BYTES*8-1:0] attr_flat,
    output logic [7:0]              smram_q,
    output logic [7:0]              smram_next
);

    // One byte register per attribute offset
    for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_attr
        localparam logic [CFG_AW-1:0] OFS = CFG_AW'(ATTR_BASE) + CFG_AW'(b);
        logic hit;
        assign hit = cfg_we && (cfg_addr == OFS);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                attr_flat[b*8 +: 8] <= 8'h00;
            end else if (hit) begin
                attr_flat[b*8 +: 8] <= cfg_wdata;
            end
        end
    end

    // SMRAM control byte; the next value feeds the low-window state machine
    always_comb begin
        smram_next = smram_q;
        if (cfg_we && (cfg_addr == CFG_AW'(SMRAM_OFS))) begin
            smram_next = cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smram_q <= SMRAM_RST;
        end else begin
            smram_q <= smram_next;
        end
    end

endmodule

// File: rtl/lma_lowwin_fsm.sv
module lma_lowwin_fsm
    import legacy_attr_pkg::*;
#(
    parameter int OPEN_BIT = 6,
    parameter int SMEN_BIT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] smram_next,
    input  logic [7:0] smram_q,
    input  logic       smm_active,
    output lowwin_t    state_q
);

    lowwin_t state_d;

    // Next-state process: to_open, to_smm, to_bus
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LW_BUS, LW_OPEN, LW_SMM: begin
                if (smram_next[OPEN_BIT]) begin
                    state_d = LW_OPEN;
                end else if (smm_active && smram_next[SMEN_BIT]) begin
                    state_d = LW_SMM;
                end else begin
                    state_d = LW_BUS;
                end
            end
            default: state_d = LW_BUS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LW_BUS;
        end else begin
            state_q <= state_d;
        end
    end

    AST_OPEN_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LW_OPEN) |-> smram_q[OPEN_BIT]); // R7

    AST_SMM_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LW_SMM) |-> ($past(smm_active) && smram_q[SMEN_BIT] && !smram_q[OPEN_BIT])); // R8

    AST_SMM_DROP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (!smm_active && !smram_next[OPEN_BIT]) |=> (state_q == LW_BUS)); // R8

endmodule

// File: rtl/lma_route_decode.sv
module lma_route_decode
    import legacy_attr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ATTR_BYTES = 7,
    parameter int SEG_COUNT  = 12,
    parameter int SEG_W      = 14
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    write,
    input  logic [ATTR_BYTES*8-1:0] attr_flat,
    input  lowwin_t                 lowwin,
    output route_t                  target,
    output logic                    wr_inhibit
);

    localparam int SIDX_W    = 20 - SEG_W;
    localparam int SEG_FIRST = 32'hC0000 >> SEG_W;
    localparam int TOP_LSB   = 4;

    logic              upper_zero;
    logic [3:0]        nib;
    logic [SIDX_W-1:0] seg_rel;
    logic [1:0]        seg_code [SEG_COUNT];
    logic [1:0]        code;
    logic              coded;

    if (ADDR_W > 20) begin : g_upper
        assign upper_zero = (addr[ADDR_W-1:20] == '0);
    end else begin : g_noupper
        assign upper_zero = 1'b1;
    end

    assign nib     = addr[19:16];
    assign seg_rel = addr[19:SEG_W] - SIDX_W'(SEG_FIRST);

    // Segment i: byte 1 + i/2, nibble i%2
    for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg
        assign seg_code[s] = attr_flat[(1 + s/2)*8 + (s%2)*4 +: 2];
    end

    always_comb begin
        code  = 2'd0;
        coded = 1'b0;
        if (upper_zero && (nib == 4'hF)) begin
            code  = attr_flat[TOP_LSB +: 2];
            coded = 1'b1;
        end else if (upper_zero && (nib >= 4'hC)) begin
            coded = 1'b1;
            for (int s = 0; s < SEG_COUNT; s++) begin
                if (seg_rel == SIDX_W'(s)) code = seg_code[s];
            end
        end
    end

    always_comb begin
        target     = TGT_DRAM;
        wr_inhibit = 1'b0;
        if (upper_zero && (nib == 4'hA || nib == 4'hB)) begin
            target = (lowwin == LW_BUS) ? TGT_BUS : TGT_DRAM;
        end else if (coded) begin
            unique case (code)
                CODE_RW: target = TGT_DRAM;
                CODE_RO: begin
                    target     = TGT_DRAM_RO;
                    wr_inhibit = write;
                end
                default: target = TGT_BUS;
            endcase
        end
    end

endmodule

// File: rtl/legacy_mem_attr_decoder.sv
module legacy_mem_attr_decoder
    import legacy_attr_pkg::*;
#(
    parameter int         ADDR_W     = 32,
    parameter int         CFG_AW     = 8,
    parameter int         SEG_COUNT  = 12,
    parameter int         SEG_W      = 14,
    parameter logic [7:0] ATTR_BASE  = 8'h59,
    parameter logic [7:0] SMRAM_OFS  = 8'h72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              smm_active,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_target,
    output logic              rsp_wr_inhibit
);

    localparam int ATTR_BYTES = 1 + (SEG_COUNT + 1) / 2;

    logic [ATTR_BYTES*8-1:0] attr_flat;
    logic [7:0]              smram_q;
    logic [7:0]              smram_next;
    lowwin_t                 lowwin;
    route_t                  dec_target;
    logic                    dec_inhibit;

    lma_cfg_regs #(
        .CFG_AW     (CFG_AW),
        .ATTR_BYTES (ATTR_BYTES),
        .ATTR_BASE  (ATTR_BASE),
        .SMRAM_OFS  (SMRAM_OFS),
        .SMRAM_RST  (8'h02)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .attr_flat  (attr_flat),
        .smram_q    (smram_q),
        .smram_next (smram_next)
    );

    lma_lowwin_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .smram_next (smram_next),
        .smram_q    (smram_q),
        .smm_active (smm_active),
        .state_q    (lowwin)
    );

    lma_route_decode #(
        .ADDR_W     (ADDR_W),
        .ATTR_BYTES (ATTR_BYTES),
        .SEG_COUNT  (SEG_COUNT),
        .SEG_W      (SEG_W)
    ) u_dec (
        .addr       (req_addr),
        .write      (req_write),
        .attr_flat  (attr_flat),
        .lowwin     (lowwin),
        .target     (dec_target),
        .wr_inhibit (dec_inhibit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_target     <= TGT_BUS;
            rsp_wr_inhibit <= 1'b0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_target     <= dec_target;
            rsp_wr_inhibit <= req_valid && dec_inhibit;
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid)); // R11

    AST_INHIBIT_IS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_inhibit |-> (rsp_target == TGT_DRAM_RO)); // R3

    AST_INHIBIT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_wr_inhibit) |-> $past(req_write)); // R3

    AST_HIGH_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_addr[19:0] < 20'hA0000)) |-> (rsp_target == TGT_DRAM && !rsp_wr_inhibit)); // R9

    AST_TARGET_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_target != 2'd3)); // R2

endmodule

// File: tb/legacy_mem_attr_decoder_tb.sv
module legacy_mem_attr_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        smm_active = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_target;
    logic        rsp_wr_inhibit;

    always #5 clk = ~clk;

    legacy_mem_attr_decoder dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_addr       (cfg_addr),
        .cfg_wdata      (cfg_wdata),
        .smm_active     (smm_active),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .rsp_valid      (rsp_valid),
        .rsp_target     (rsp_target),
        .rsp_wr_inhibit (rsp_wr_inhibit)
    );

    localparam logic [1:0] T_DRAM = 2'd0;
    localparam logic [1:0] T_RO   = 2'd1;
    localparam logic [1:0] T_BUS  = 2'd2;

    typedef struct {
        logic [31:0] addr;
        logic [1:0]  tgt;
        logic        inh;
        string       rq;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    task automatic check_bit(input string rq, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", rq, what, act, exp);
        end
    endtask

    // Driver: drive one request and push its expected result
    task automatic send(input logic [31:0] a, input logic wr, input logic [1:0] tgt,
                        input logic inh, input string rq);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        e.addr = a; e.tgt = tgt; e.inh = inh; e.rq = rq;
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] ofs, input logic [7:0] val);
        idle();
        cfg_we    = 1'b1;
        cfg_addr  = ofs;
        cfg_wdata = val;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic set_smm(input logic v);
        idle();
        smm_active = v;
        @(negedge clk);
    endtask

    // Monitor: pop and compare each response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected response actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_target !== e.tgt || rsp_wr_inhibit !== e.inh) begin
                    n_fail++;
                    $display("FAIL %s addr=%h actual=tgt%0d/inh%0b expected=tgt%0d/inh%0b",
                             e.rq, e.addr, rsp_target, rsp_wr_inhibit, e.tgt, e.inh);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_bit("R11", rsp_valid, 1'b0, "rsp_valid in reset");
        rst_n = 1'b1;
        smm_active = 1'b1;
        @(negedge clk);

        // R1: reset state
        send(32'h000C0000, 1'b0, T_BUS, 1'b0, "R1");
        send(32'h000F0000, 1'b1, T_BUS, 1'b0, "R1");
        send(32'h000A0000, 1'b0, T_BUS, 1'b0, "R1");
        send(32'h000EFFFF, 1'b0, T_BUS, 1'b0, "R1");
        set_smm(1'b0);

        // R5 / R2 / R3: segment 0 code 3, segment 1 code 1
        cfg_write(8'h5A, 8'h13);
        send(32'h000C0000, 1'b1, T_DRAM, 1'b0, "R2");
        send(32'h000C3FFF, 1'b0, T_DRAM, 1'b0, "R5");
        send(32'h000C4000, 1'b0, T_RO,   1'b0, "R3");
        send(32'h000C7FFF, 1'b1, T_RO,   1'b1, "R3");
        send(32'h000C8000, 1'b1, T_BUS,  1'b0, "R5");

        // R4 / R5: last byte, codes 0 and 2, ignored bits set
        cfg_write(8'h5F, 8'h2C);
        send(32'h000E8000, 1'b0, T_BUS, 1'b0, "R4");
        send(32'h000EC000, 1'b1, T_BUS, 1'b0, "R4");
        cfg_write(8'h5F, 8'hC3);
        send(32'h000EBFFF, 1'b1, T_DRAM, 1'b0, "R5");
        send(32'h000EFFFF, 1'b0, T_BUS,  1'b0, "R5");

        // R6: top window
        cfg_write(8'h59, 8'h30);
        send(32'h000F0000, 1'b0, T_DRAM, 1'b0, "R6");
        send(32'h000FFFFF, 1'b1, T_DRAM, 1'b0, "R6");
        cfg_write(8'h59, 8'h13);
        send(32'h000F8000, 1'b0, T_RO, 1'b0, "R6");
        send(32'h000FFFFF, 1'b1, T_RO, 1'b1, "R6");

        // R10: writes to unrelated offsets
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        cfg_write(8'h73, 8'hFF);
        send(32'h000C8000, 1'b0, T_BUS, 1'b0, "R10");
        send(32'h000A0000, 1'b0, T_BUS, 1'b0, "R10");
        send(32'h000D0000, 1'b1, T_BUS, 1'b0, "R10");

        // R7: open bit
        cfg_write(8'h72, 8'h40);
        send(32'h000A0000, 1'b0, T_DRAM, 1'b0, "R7");
        send(32'h000BFFFF, 1'b1, T_DRAM, 1'b0, "R7");
        set_smm(1'b1);
        send(32'h000B0000, 1'b1, T_DRAM, 1'b0, "R7");
        set_smm(1'b0);

        // R8: SMM-gated window
        cfg_write(8'h72, 8'h08);
        send(32'h000B0000, 1'b0, T_BUS, 1'b0, "R8");
        set_smm(1'b1);
        send(32'h000B0000, 1'b0, T_DRAM, 1'b0, "R8");
        send(32'h000A8000, 1'b1, T_DRAM, 1'b0, "R8");
        set_smm(1'b0);
        send(32'h000B0000, 1'b0, T_BUS, 1'b0, "R8");
        cfg_write(8'h72, 8'h00);
        set_smm(1'b1);
        send(32'h000A0000, 1'b0, T_BUS, 1'b0, "R8");
        set_smm(1'b0);

        // R9: outside the legacy range
        send(32'h0009FFFF, 1'b1, T_DRAM, 1'b0, "R9");
        send(32'h00100000, 1'b0, T_DRAM, 1'b0, "R9");
        send(32'h100C4000, 1'b1, T_DRAM, 1'b0, "R9");
        send(32'h000FFFFF, 1'b1, T_RO,   1'b1, "R3");
        idle();

        repeat (4) @(negedge clk);
        check_bit("R11", rsp_valid, 1'b0, "rsp_valid after idle");
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R11 missing responses actual=%0d expected=0", exp_q.size());
        end
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule